// File: doc/BRIEF.md
# Interrupt Status Aggregator with Selective Clear

This block gathers the interrupt sources of a DMA engine into one 32-bit status word and drives a single level-sensitive interrupt line. Ten single-cycle event pulses set sticky flags in the low bits of the word. Six level summaries from neighbouring sub-blocks appear directly in a middle field. Those levels can only be cleared at their sources. A 13-bit completion index supplied from outside is mirrored into the top bits.

Software reaches the block through a simple register port with combinational read data. Reading the status address returns the word and clears every sticky flag. Reading the alias address returns the same word but clears only the flags whose clear-select bit is set, so a polling agent can consume some events and leave the rest for another agent. A 32-bit mask, with the same layout as the status word, decides which bits may drive the interrupt line.

Top module: `irq_status_agg`

## Requirements
- R1: Out of reset all sticky flags are 0, the mask reads 32'hFFFF_FFFF, the clear-select register is 0 and irq_o is low.
- R2: A 1 on evt_pulse_i[k] (k in 0..9) sets status bit k from the next cycle, and the bit stays set until a clearing read.
- R3: A read at address 0 returns the status word in the same cycle, and all sticky flags (bits 0..9) are 0 in the following cycle.
- R4: A read at address 3 returns the same word as address 0, and in the next cycle it clears only the sticky flags whose bit in the clear-select register is 1. The clear-select register is written at address 2 from wdata bits 9..0 and reads back as 0.
- R5: With the clear-select register still at its reset value, an alias read leaves every sticky flag unchanged.
- R6: Status bits 18..13 equal src_level_i[5:0] in every cycle, and no read changes them.
- R7: Status bits 31..19 equal tx_comp_idx_i[12:0] in every cycle.
- R8: The mask is written and read at address 1 (all 32 bits). irq_o is the OR of status bits 0..9 and 13..18 whose mask bit is 0. Status bits 10 and 11 read as 0.
- R9: Status bit 12 reads as 1 exactly when irq_o is high.
- R10: An event pulse in the same cycle as a clearing read, through either address, leaves its flag set after that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_en_i | input | 1 | Register access in this cycle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 2 | 0 status, 1 mask, 2 clear-select, 3 status alias |
| req_wdata_i | input | 32 | Write data |
| rsp_rdata_o | output | 32 | Read data for the addressed register (combinational) |
| evt_pulse_i | input | 10 | Single-cycle event pulses for sticky bits 0..9 |
| src_level_i | input | 6 | Sub-block summary levels for bits 13..18 |
| tx_comp_idx_i | input | 13 | Completion index mirrored into bits 19..31 |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions assume that req_addr_i, req_we_i, evt_pulse_i and src_level_i are known and stable around each rising edge. They also assume that a read is a single-cycle strobe, so that one clearing action maps to one edge. The stimulus changes every input only on the falling edge and returns req_en_i and evt_pulse_i to 0 after each access. The level and index inputs are held steady across each access, so the combinational read data sampled before the edge reflects the state the bench model predicts.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned EVT_N   = 10;
  localparam int unsigned SUM_POS = 12;
  localparam int unsigned LVL_LSB = 13;
  localparam int unsigned LVL_N   = 6;
  localparam int unsigned IDX_LSB = LVL_LSB + LVL_N;
  localparam int unsigned IDX_W   = DATA_W - IDX_LSB;
  localparam int unsigned IRQ_TOP = LVL_LSB + LVL_N - 1;
  localparam int unsigned ADDR_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_STATUS = 2'd0,
    ADDR_MASK   = 2'd1,
    ADDR_CSEL   = 2'd2,
    ADDR_ALIAS  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_event_latch.sv
module irq_event_latch #(
  parameter int unsigned N = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] lat_o
);
  logic [N-1:0] lat_q;

  // set wins over a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_q <= '0;
    else         lat_q <= (lat_q & ~clr_i) | set_i;
  end

  assign lat_o = lat_q;
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CSEL_N = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_mask_i,
  input  logic              wr_csel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] mask_o,
  output logic [CSEL_N-1:0] csel_o
);
  logic [DATA_W-1:0] mask_q;
  logic [CSEL_N-1:0] csel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      csel_q <= '0;
    end else begin
      if (wr_mask_i) mask_q <= wdata_i;
      if (wr_csel_i) csel_q <= wdata_i[CSEL_N-1:0];
    end
  end

  assign mask_o = mask_q;
  assign csel_o = csel_q;
endmodule

// File: rtl/irq_word_build.sv
module irq_word_build
  import irq_agg_pkg::*;
(
  input  logic [EVT_N-1:0]   lat_i,
  input  logic [LVL_N-1:0]   lvl_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [IRQ_TOP:0]   mask_i,
  output logic [DATA_W-1:0]  status_o,
  output logic               irq_o
);
  logic [IRQ_TOP:0] raw;
  logic [IRQ_TOP:0] live;

  for (genvar b = 0; b <= IRQ_TOP; b++) begin : g_raw
    if (b < EVT_N) begin : g_evt
      assign raw[b] = lat_i[b];
    end else if (b >= LVL_LSB) begin : g_lvl
      assign raw[b] = lvl_i[b-LVL_LSB];
    end else begin : g_gap
      assign raw[b] = 1'b0;
    end
  end

  assign live  = raw & ~mask_i;
  assign irq_o = |live;

  always_comb begin
    status_o                        = '0;
    status_o[IRQ_TOP:0]             = raw;
    status_o[SUM_POS]               = irq_o;
    status_o[DATA_W-1:IDX_LSB]      = idx_i;
  end
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_agg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_en_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic [EVT_N-1:0]  evt_pulse_i,
  input  logic [LVL_N-1:0]  src_level_i,
  input  logic [IDX_W-1:0]  tx_comp_idx_i,
  output logic              irq_o
);
  logic              rd_en, wr_en;
  logic              rd_status, rd_alias;
  logic [EVT_N-1:0]  clr;
  logic [EVT_N-1:0]  lat_q;
  logic [EVT_N-1:0]  csel;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] status_word;

  assign rd_en     = req_en_i & ~req_we_i;
  assign wr_en     = req_en_i &  req_we_i;
  assign rd_status = rd_en && (req_addr_i == ADDR_STATUS);
  assign rd_alias  = rd_en && (req_addr_i == ADDR_ALIAS);

  always_comb begin
    if (rd_status)     clr = '1;
    else if (rd_alias) clr = csel;
    else               clr = '0;
  end

  irq_event_latch #(.N(EVT_N)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt_pulse_i),
    .clr_i  (clr),
    .lat_o  (lat_q)
  );

  irq_ctrl_regs #(.DATA_W(DATA_W), .CSEL_N(EVT_N)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_mask_i (wr_en && (req_addr_i == ADDR_MASK)),
    .wr_csel_i (wr_en && (req_addr_i == ADDR_CSEL)),
    .wdata_i   (req_wdata_i),
    .mask_o    (mask),
    .csel_o    (csel)
  );

  irq_word_build u_build (
    .lat_i    (lat_q),
    .lvl_i    (src_level_i),
    .idx_i    (tx_comp_idx_i),
    .mask_i   (mask[IRQ_TOP:0]),
    .status_o (status_word),
    .irq_o    (irq_o)
  );

  always_comb begin
    unique case (req_addr_i)
      ADDR_STATUS, ADDR_ALIAS: rsp_rdata_o = status_word;
      ADDR_MASK:               rsp_rdata_o = mask;
      default:                 rsp_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_status_agg_chk.sv
module irq_status_agg_chk
  import irq_agg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [EVT_N-1:0]  evt_i,
  input logic              rd_status_i,
  input logic              rd_alias_i,
  input logic [EVT_N-1:0]  lat_i,
  input logic [EVT_N-1:0]  csel_i,
  input logic [DATA_W-1:0] mask_i,
  input logic [LVL_N-1:0]  lvl_i,
  input logic [IDX_W-1:0]  idx_i,
  input logic              irq_i,
  input logic [DATA_W-1:0] rdata_i
);
  // R2: a flag never appears without its event
  a_r2_no_spurious_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((lat_i & ~$past(lat_i) & ~$past(evt_i)) == '0));

  // R3: status read empties every flag that had no new event
  a_r3_status_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_status_i |=> ((lat_i & ~$past(evt_i)) == '0));

  // R4: alias read keeps flags outside the clear selection
  a_r4_alias_keeps_unselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_alias_i |=> (($past(lat_i) & ~$past(csel_i) & ~lat_i) == '0));

  a_r4_alias_clears_selected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_alias_i |=> ((lat_i & $past(csel_i) & ~$past(evt_i)) == '0));

  // R10: a coincident event survives any clearing read
  a_r10_event_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((lat_i & $past(evt_i)) == $past(evt_i)));

  // R6, R7: pass-through fields on any status-type read
  a_r6_levels_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_status_i || rd_alias_i) |-> (rdata_i[IRQ_TOP:LVL_LSB] == lvl_i));

  a_r7_index_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_status_i || rd_alias_i) |-> (rdata_i[DATA_W-1:IDX_LSB] == idx_i));

  // R8: everything masked keeps the line low
  a_r8_all_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_i[IRQ_TOP:0]) |-> !irq_i);

  // R9: summary bit tracks the line
  a_r9_summary_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_status_i || rd_alias_i) |-> (rdata_i[SUM_POS] == irq_i));
endmodule

bind irq_status_agg irq_status_agg_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .evt_i       (evt_pulse_i),
  .rd_status_i (rd_status),
  .rd_alias_i  (rd_alias),
  .lat_i       (lat_q),
  .csel_i      (csel),
  .mask_i      (mask),
  .lvl_i       (src_level_i),
  .idx_i       (tx_comp_idx_i),
  .irq_i       (irq_o),
  .rdata_i     (rsp_rdata_o)
);

// File: tb/irq_status_agg_tb.sv
`timescale 1ns/1ps
module irq_status_agg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_en = 1'b0, req_we = 1'b0;
  logic [1:0]  req_addr = 2'd0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rdata;
  logic [9:0]  evt = '0;
  logic [5:0]  lvl = '0;
  logic [12:0] idx = '0;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model
  logic [9:0]  m_lat  = '0;
  logic [31:0] m_mask = '1;
  logic [9:0]  m_csel = '0;

  always #2 clk = ~clk;

  irq_status_agg u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_en_i(req_en), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .rsp_rdata_o(rdata),
    .evt_pulse_i(evt), .src_level_i(lvl), .tx_comp_idx_i(idx), .irq_o(irq)
  );

  function automatic logic exp_irq();
    return (|(m_lat & ~m_mask[9:0])) | (|(lvl & ~m_mask[18:13]));
  endfunction

  function automatic logic [31:0] exp_status();
    return {idx, lvl, exp_irq(), 2'b00, m_lat};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one access cycle; inputs set on falling edge, outputs sampled before rising edge
  task automatic access(input logic en, input logic we, input logic [1:0] addr,
                        input logic [31:0] wd, input logic [9:0] ev,
                        output logic [31:0] rd, output logic irq_s);
    @(negedge clk);
    req_en = en; req_we = we; req_addr = addr; req_wdata = wd; evt = ev;
    #1;
    rd = rdata; irq_s = irq;
    @(posedge clk);
    if (en && !we && addr == 2'd0)      m_lat = ev;
    else if (en && !we && addr == 2'd3) m_lat = (m_lat & ~m_csel) | ev;
    else                                m_lat = m_lat | ev;
    if (en && we && addr == 2'd1) m_mask = wd;
    if (en && we && addr == 2'd2) m_csel = wd[9:0];
    #1;
    req_en = 1'b0; evt = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] addr, input logic [9:0] ev);
    logic [31:0] exp, got; logic ei, gi;
    exp = (addr == 2'd1) ? m_mask : (addr == 2'd2) ? 32'd0 : exp_status();
    ei  = exp_irq();
    access(1'b1, 1'b0, addr, '0, ev, got, gi);
    check(tag, got, exp);
    check({tag, " irq_o"}, {31'd0, gi}, {31'd0, ei});
  endtask

  task automatic wr(input logic [1:0] addr, input logic [31:0] wd);
    logic [31:0] d; logic i;
    access(1'b1, 1'b1, addr, wd, '0, d, i);
  endtask

  task automatic pulse(input logic [9:0] ev);
    logic [31:0] d; logic i;
    access(1'b0, 1'b0, 2'd0, '0, ev, d, i);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    rd_chk("R1 status after reset", 2'd0, '0);
    rd_chk("R1 mask after reset", 2'd1, '0);
    rd_chk("R1 clear-select reads zero", 2'd2, '0);

    // R8 mask read/write
    foreach (m_csel[k]) begin end
    for (int p = 0; p < 4; p++) begin
      wr(2'd1, 32'hA5A5_0F0F ^ (32'h1111_1111 << p));
      rd_chk("R8 mask readback", 2'd1, '0);
    end
    wr(2'd1, '1);

    // R2/R3 each event bit latches, status read clears
    for (int i = 0; i < 10; i++) begin
      pulse(10'(1 << i));
      pulse('0);
      rd_chk("R2 event latched", 2'd0, '0);
      rd_chk("R3 cleared after status read", 2'd0, '0);
    end

    // R8/R9 unmask each interrupt position
    for (int b = 0; b < 19; b++) begin
      if (b >= 10 && b <= 12) continue;
      wr(2'd1, ~(32'd1 << b));
      lvl = (b >= 13) ? 6'(1 << (b - 13)) : 6'd0;
      if (b < 10) pulse(10'(1 << b));
      rd_chk("R8 R9 unmasked source raises irq", 2'd0, '0);
      rd_chk("R9 after clearing read", 2'd0, '0);
      pulse(10'h3FF);
      lvl = 6'h3F;
      rd_chk("R8 other sources stay masked", 2'd0, '0);
      lvl = '0;
    end
    wr(2'd1, '1);

    // R6 level field, unaffected by reads
    for (int v = 0; v < 64; v += 9) begin
      lvl = 6'(v);
      rd_chk("R6 levels on status read", 2'd0, '0);
      rd_chk("R6 levels survive status read", 2'd0, '0);
      rd_chk("R6 levels on alias read", 2'd3, '0);
    end
    lvl = '0;

    // R7 index mirror
    for (int v = 0; v < 13; v++) begin
      idx = 13'(1 << v) ^ 13'h0AAA;
      rd_chk("R7 index mirror", 2'd0, '0);
    end
    idx = 13'h1FFF;
    rd_chk("R7 index all ones", 2'd3, '0);

    // R5 clear-select at reset value: alias read clears nothing
    pulse(10'h3FF);
    rd_chk("R5 alias read with zero select", 2'd3, '0);
    rd_chk("R5 flags still set", 2'd0, '0);

    // R4 partial clears
    for (int s = 0; s < 4; s++) begin
      wr(2'd2, 32'(10'h155 >> s) | 32'hFFFF_FC00);
      rd_chk("R4 clear-select reads zero", 2'd2, '0);
      pulse(10'h3FF);
      rd_chk("R4 alias read value", 2'd3, '0);
      rd_chk("R4 only selected bits cleared", 2'd3, '0);
      rd_chk("R4 final status", 2'd0, '0);
    end

    // R10 coincident event with clearing reads
    pulse(10'h0F0);
    rd_chk("R10 status read with event", 2'd0, 10'h2A5);
    rd_chk("R10 event survived status read", 2'd0, '0);
    wr(2'd2, 32'h3FF);
    pulse(10'h3FF);
    rd_chk("R10 alias read with event", 2'd3, 10'h10A);
    rd_chk("R10 event survived alias read", 2'd0, '0);
    wr(2'd1, 32'h0);
    pulse(10'h001);
    rd_chk("R9 summary with all unmasked", 2'd3, '0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule